// File: doc/BRIEF.md
# Register-Mapped Signed Divider

This block is a small divider that software drives through a word-addressed register window. Software first loads a 32-bit divisor. Writing a 32-bit dividend to one register starts a 32-by-32 signed divide. Writing the low half of a 64-bit dividend to another register starts a 64-by-32 signed divide. For the 64-bit case, the high half must already sit in the remainder register.

The unit works on magnitudes with a restoring shift-subtract loop that retires one quotient bit per clock. It then fixes up the signs. A quotient that will not fit in 32 signed bits is clamped. The remainder and quotient each land in a primary register and in a mirror register. In the short mode the quotient also overwrites the dividend register.

A busy output covers the whole operation. While it is high, register writes are dropped and reads return whatever the registers held before.

Top module: `sdiv_regs`

## Requirements
- R1: After reset every register reads zero and `busy` is low.
- R2: Word offsets are: divisor 0x00, short dividend 0x04, remainder or high dividend 0x10, quotient or low dividend 0x14, remainder mirror 0x18, quotient mirror 0x1C. Writes to any of these read back unchanged while idle. Offsets 0x08 and 0x0C read zero and ignore writes.
- R3: An idle write to 0x04 with a nonzero divisor divides the written value by the divisor. The quotient goes to 0x04, 0x14 and 0x1C. The remainder goes to 0x10 and 0x18.
- R4: An idle write to 0x14 with a nonzero divisor divides the 64-bit value {0x10, written word} by the divisor. The quotient goes to 0x14 and 0x1C, and the remainder goes to 0x10 and 0x18.
- R5: The quotient truncates toward zero. The remainder has the sign of the dividend, and its magnitude is below the divisor's magnitude.
- R6: If the true quotient lies outside [-2^31, 2^31-1], the quotient registers read 0x7FFFFFFF when the true quotient is positive and 0x80000000 when it is negative. The remainder still holds the exact remainder. This applies in both modes, so -2^31 / -1 in the short mode gives 0x7FFFFFFF with remainder 0.
- R7: A start with a zero divisor clears 0x10, 0x14, 0x18 and 0x1C at that same clock edge, and `busy` stays low. A short-mode start leaves 0x04 holding the written value.
- R8: After a start with a nonzero divisor, `busy` is high for exactly 33 cycles in the short mode and 65 cycles in the long mode. The results are readable once it falls.
- R9: While `busy` is high, every write is ignored, and reads return the register contents from before the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the register, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| busy | output | 1 | Division in progress |

## Verification
The bench goes after the sign corners: mixed-sign operands where a floor-style divider would round -7/2 to -4 instead of -3, or would give the remainder the divisor's sign. It probes the saturation boundary from both sides. A quotient of exactly -2^31 must pass unclamped, while a quotient one step beyond either limit must clamp. An off-by-one limit or a swapped clamp value shows up there. Zero divisors in both modes catch a design that stalls or leaves stale results. Writes issued mid-operation, to the divisor and to a mirror, catch a design that lets a new divisor leak into a running loop or lets a mirror be overwritten before the posting.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
package sdiv_pkg;
    // word indices (byte offset / 4) of the register window
    localparam int unsigned IDX_DVS  = 0;
    localparam int unsigned IDX_DVD  = 1;
    localparam int unsigned IDX_REM  = 4;
    localparam int unsigned IDX_QUO  = 5;
    localparam int unsigned IDX_REMM = 6;
    localparam int unsigned IDX_QUOM = 7;

    typedef enum logic {
        MODE_SHORT = 1'b0,
        MODE_LONG  = 1'b1
    } div_mode_e;
endpackage

// File: rtl/sdiv_core.sv
`timescale 1ns/1ps
module sdiv_core
    import sdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  div_mode_e      mode,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] quo_mag,
    output logic [W-1:0]   rem_mag,
    output logic           q_neg,
    output logic           r_neg
);
    localparam int DW = 2 * W;
    localparam int CW = $clog2(DW + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W:0]    acc;
        logic [DW-1:0] quo;
        logic [W-1:0]  dvs;
        logic          qn;
        logic          rn;
    } core_t;

    core_t s_d, s_q;

    logic [W:0]    shifted;
    logic [W:0]    diff;
    logic [DW-1:0] dvd_mag;
    logic [W-1:0]  dvs_mag;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        shifted  = {s_q.acc[W-1:0], s_q.quo[DW-1]};
        diff     = shifted - {1'b0, s_q.dvs};
        dvd_mag  = dividend[DW-1] ? (~dividend + 1'b1) : dividend;
        dvs_mag  = divisor[W-1] ? (~divisor + 1'b1) : divisor;
        if (start) begin
            s_d.busy = 1'b1;
            s_d.acc  = '0;
            s_d.dvs  = dvs_mag;
            s_d.qn   = dividend[DW-1] ^ divisor[W-1];
            s_d.rn   = dividend[DW-1];
            if (mode == MODE_LONG) begin
                s_d.quo = dvd_mag;
                s_d.cnt = CW'(DW);
            end else begin
                s_d.quo = {dvd_mag[W-1:0], {W{1'b0}}};
                s_d.cnt = CW'(W);
            end
        end else if (s_q.busy) begin
            if (shifted >= {1'b0, s_q.dvs}) begin
                s_d.acc = diff;
                s_d.quo = {s_q.quo[DW-2:0], 1'b1};
            end else begin
                s_d.acc = shifted;
                s_d.quo = {s_q.quo[DW-2:0], 1'b0};
            end
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == CW'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign quo_mag = s_q.quo;
    assign rem_mag = s_q.acc[W-1:0];
    assign q_neg   = s_q.qn;
    assign r_neg   = s_q.rn;

    // R8: a start always enters the running state
    a_r8_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !done));
    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5: final remainder magnitude below divisor magnitude
    a_r5_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (s_q.acc < {1'b0, s_q.dvs}));
endmodule

// File: rtl/sdiv_fix.sv
`timescale 1ns/1ps
module sdiv_fix #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] quo_mag,
    input  logic [W-1:0]   rem_mag,
    input  logic           q_neg,
    input  logic           r_neg,
    output logic [W-1:0]   quo,
    output logic [W-1:0]   rem,
    output logic           ovf
);
    localparam int DW = 2 * W;
    localparam logic [DW-1:0] POS_LIM = {{(W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic [DW-1:0] NEG_LIM = POS_LIM + 1'b1;
    localparam logic [W-1:0]  SAT_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0]  SAT_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] q_low;

    always_comb begin
        q_low = quo_mag[W-1:0];
        ovf   = q_neg ? (quo_mag > NEG_LIM) : (quo_mag > POS_LIM);
        if (ovf)        quo = q_neg ? SAT_NEG : SAT_POS;
        else if (q_neg) quo = ~q_low + 1'b1;
        else            quo = q_low;
        rem = r_neg ? (~rem_mag + 1'b1) : rem_mag;
    end
endmodule

// File: rtl/sdiv_regs.sv
`timescale 1ns/1ps
module sdiv_regs
    import sdiv_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          busy
);
    localparam int DW = 2 * W;
    localparam int IW = AW - 2;
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

    typedef struct packed {
        logic [W-1:0] dvs;
        logic [W-1:0] dvd;
        logic [W-1:0] rem;
        logic [W-1:0] quo;
        logic [W-1:0] rem_m;
        logic [W-1:0] quo_m;
        div_mode_e    mode;
    } regs_t;

    regs_t r_d, r_q;

    logic [IW-1:0] widx;
    logic          start;
    div_mode_e     start_mode;
    logic [DW-1:0] start_dvd;

    logic          core_busy, core_done, core_qn, core_rn;
    logic [DW-1:0] core_quo;
    logic [W-1:0]  core_rem;
    logic [W-1:0]  fix_quo, fix_rem;
    logic          fix_ovf;

    assign widx = addr[AW-1:2];
    assign busy = core_busy | core_done;

    sdiv_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode     (start_mode),
        .dividend (start_dvd),
        .divisor  (r_q.dvs),
        .busy     (core_busy),
        .done     (core_done),
        .quo_mag  (core_quo),
        .rem_mag  (core_rem),
        .q_neg    (core_qn),
        .r_neg    (core_rn)
    );

    sdiv_fix #(.W(W)) u_fix (
        .quo_mag (core_quo),
        .rem_mag (core_rem),
        .q_neg   (core_qn),
        .r_neg   (core_rn),
        .quo     (fix_quo),
        .rem     (fix_rem),
        .ovf     (fix_ovf)
    );

    always_comb begin
        r_d        = r_q;
        start      = 1'b0;
        start_mode = MODE_SHORT;
        start_dvd  = {{W{wdata[W-1]}}, wdata};
        if (core_done) begin
            r_d.rem   = fix_rem;
            r_d.rem_m = fix_rem;
            r_d.quo   = fix_quo;
            r_d.quo_m = fix_quo;
            if (r_q.mode == MODE_SHORT) r_d.dvd = fix_quo;
        end else if (wr_en && !core_busy) begin
            case (widx)
                IW'(IDX_DVS): r_d.dvs = wdata;
                IW'(IDX_DVD): begin
                    r_d.dvd = wdata;
                    if (r_q.dvs == '0) begin
                        r_d.rem = '0; r_d.quo = '0; r_d.rem_m = '0; r_d.quo_m = '0;
                    end else begin
                        start      = 1'b1;
                        start_mode = MODE_SHORT;
                        r_d.mode   = MODE_SHORT;
                    end
                end
                IW'(IDX_REM):  r_d.rem = wdata;
                IW'(IDX_QUO): begin
                    start_dvd = {r_q.rem, wdata};
                    if (r_q.dvs == '0) begin
                        r_d.rem = '0; r_d.quo = '0; r_d.rem_m = '0; r_d.quo_m = '0;
                    end else begin
                        r_d.quo    = wdata;
                        start      = 1'b1;
                        start_mode = MODE_LONG;
                        r_d.mode   = MODE_LONG;
                    end
                end
                IW'(IDX_REMM): r_d.rem_m = wdata;
                IW'(IDX_QUOM): r_d.quo_m = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (widx)
            IW'(IDX_DVS):  rdata = r_q.dvs;
            IW'(IDX_DVD):  rdata = r_q.dvd;
            IW'(IDX_REM):  rdata = r_q.rem;
            IW'(IDX_QUO):  rdata = r_q.quo;
            IW'(IDX_REMM): rdata = r_q.rem_m;
            IW'(IDX_QUOM): rdata = r_q.quo_m;
            default:       rdata = '0;
        endcase
    end

    // R9: divisor cannot change while an operation runs
    a_r9_divisor_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(r_q.dvs));
    // R9: results stay put until the posting edge
    a_r9_results_held: assert property (@(posedge clk) disable iff (!rst_n)
        (core_busy && !core_done) |=> ($stable(r_q.rem_m) && $stable(r_q.quo_m)));
    // R3 / R4: primary and mirror registers agree after posting
    a_r3_r4_mirrors: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> (r_q.rem == r_q.rem_m && r_q.quo == r_q.quo_m));
    // R6: clamp values follow the sign of the true quotient
    a_r6_clamp_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && fix_ovf && core_qn) |=> (r_q.quo_m == MIN_NEG));
    a_r6_clamp_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && fix_ovf && !core_qn) |=> (r_q.quo_m == MAX_POS));
    // R7: zero divisor clears results without going busy
    a_r7_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && widx == IW'(IDX_QUO) && r_q.dvs == '0) |=>
        (r_q.quo == '0 && r_q.rem == '0 && r_q.quo_m == '0 && r_q.rem_m == '0 && !busy));
endmodule

// File: tb/sim_sdiv_regs.sv
`timescale 1ns/1ps
module sim_sdiv_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        busy;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    sdiv_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    function automatic void ref_div(input logic [63:0] dvd, input logic [31:0] dvs,
                                    output logic [31:0] q, output logic [31:0] r);
        logic [63:0] md, ms, qm, rm;
        logic        qn, ovf;
        md = dvd[63] ? (~dvd + 64'd1) : dvd;
        ms = dvs[31] ? {32'h0, (~dvs + 32'd1)} : {32'h0, dvs};
        if (dvs == 32'h0) begin
            q = 32'h0; r = 32'h0;
        end else begin
            qm  = md / ms;
            rm  = md % ms;
            qn  = dvd[63] ^ dvs[31];
            ovf = qn ? (qm > 64'h8000_0000) : (qm > 64'h7FFF_FFFF);
            if (ovf)     q = qn ? 32'h8000_0000 : 32'h7FFF_FFFF;
            else if (qn) q = ~qm[31:0] + 32'd1;
            else         q = qm[31:0];
            r = dvd[63] ? (~rm[31:0] + 32'd1) : rm[31:0];
        end
    endfunction

    // one operation: long=1 uses {hi,lo}, else lo alone
    task automatic run_op(input bit long_mode, input logic [31:0] hi,
                          input logic [31:0] lo, input logic [31:0] dvs, input string tag);
        logic [31:0] eq, er, v;
        logic [63:0] dvd;
        int n;
        dvd = long_mode ? {hi, lo} : {{32{lo[31]}}, lo};
        ref_div(dvd, dvs, eq, er);
        wr(5'h00, dvs);
        if (long_mode) begin
            wr(5'h10, hi);
            wr(5'h14, lo);
        end else begin
            wr(5'h04, lo);
        end
        n = 0;
        while (busy && n < 200) begin
            n++;
            @(negedge clk);
        end
        // R8 busy length, R7 zero divisor never busy
        chk(dvs == 0 ? "R7 busy" : "R8 busy", n, dvs == 0 ? 0 : (long_mode ? 65 : 33));
        rd(5'h14, v); chk(tag, v, eq);
        rd(5'h1C, v); chk(tag, v, eq);
        rd(5'h10, v); chk(tag, v, er);
        rd(5'h18, v); chk(tag, v, er);
        if (!long_mode) begin
            rd(5'h04, v); chk(tag, v, dvs == 0 ? lo : eq);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] r32;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'h0, busy}, 32'h0);
        for (int i = 0; i < 8; i++) begin
            rd(5'(i * 4), v); chk("R1 reset", v, 32'h0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R2 map and unmapped offsets
        wr(5'h08, 32'h1234_5678);
        rd(5'h08, v); chk("R2 unmapped 08", v, 32'h0);
        wr(5'h0C, 32'hCAFE_F00D);
        rd(5'h0C, v); chk("R2 unmapped 0C", v, 32'h0);
        wr(5'h18, 32'hA5A5_0001); rd(5'h18, v); chk("R2 rem mirror rw", v, 32'hA5A5_0001);
        wr(5'h1C, 32'h5A5A_0002); rd(5'h1C, v); chk("R2 quo mirror rw", v, 32'h5A5A_0002);
        wr(5'h10, 32'h0000_0BEE); rd(5'h10, v); chk("R2 rem rw", v, 32'h0000_0BEE);
        wr(5'h00, 32'h0000_0011); rd(5'h00, v); chk("R2 divisor rw", v, 32'h0000_0011);
        // R5 sign corners, short mode
        run_op(1'b0, 32'h0, 32'hFFFF_FFF9, 32'd2, "R3/R5 -7/2");
        run_op(1'b0, 32'h0, 32'd7, 32'hFFFF_FFFE, "R3/R5 7/-2");
        run_op(1'b0, 32'h0, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R3/R5 -7/-2");
        // R6 short-mode overflow
        run_op(1'b0, 32'h0, 32'h8000_0000, 32'hFFFF_FFFF, "R6 short min/-1");
        // R6 long-mode boundaries
        run_op(1'b1, 32'h1, 32'h0, 32'h1, "R6 long pos clamp");
        run_op(1'b1, 32'h1, 32'h0, 32'hFFFF_FFFF, "R6 long neg clamp");
        run_op(1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1, "R6 exact min fits");
        run_op(1'b1, 32'h0, 32'h8000_0000, 32'h1, "R6 one past max");
        run_op(1'b1, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF, "R6 64-bit min/-1");
        run_op(1'b1, 32'h0000_0003, 32'h1234_5678, 32'h7FFF_FFFF, "R4/R5 long big dvs");
        // R7 zero divisor, both modes
        run_op(1'b0, 32'h0, 32'h0000_1234, 32'h0, "R7 short zero");
        run_op(1'b1, 32'h7, 32'h0000_1234, 32'h0, "R7 long zero");
        // R9 writes ignored, reads hold during busy
        run_op(1'b0, 32'h0, 32'd100, 32'd7, "R3 setup");
        wr(5'h00, 32'd3);
        wr(5'h10, 32'h0);
        wr(5'h14, 32'd1000);
        chk("R9 busy after start", {31'h0, busy}, 32'h1);
        wr(5'h00, 32'd5);
        wr(5'h18, 32'hDEAD_BEEF);
        rd(5'h1C, v); chk("R9 read during busy", v, 32'd14);
        rd(5'h18, v); chk("R9 mirror write ignored", v, 32'd2);
        while (busy) @(negedge clk);
        rd(5'h00, v); chk("R9 divisor write ignored", v, 32'd3);
        rd(5'h14, v); chk("R9/R4 result uses old divisor", v, 32'd333);
        rd(5'h18, v); chk("R9/R4 remainder", v, 32'd1);
        // random mix
        for (int k = 0; k < 60; k++) begin
            logic [31:0] hi, lo, dv;
            int sel;
            hi = $urandom; lo = $urandom; dv = $urandom;
            sel = int'($urandom % 16);
            if (sel < 4)       dv = 32'($signed(int'($urandom % 17) - 8));
            else if (sel == 4) dv = 32'h0;
            else if (sel < 8)  dv = {{16{dv[31]}}, dv[15:0]};
            r32 = $urandom;
            if (r32[0]) hi = {{31{hi[31]}}, hi[0]};
            if (k % 2 == 0) run_op(1'b0, 32'h0, lo, dv, "R3/R5 random short");
            else            run_op(1'b1, hi, lo, dv, "R4/R5/R6 random long");
        end
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule